// File: doc/BRIEF.md
# Microsecond Delay Timer

This block is a 16-bit down-counter that software loads with a delay expressed in microseconds. A prescaler divides the system clock to a 1 MHz tick. Each tick takes one from the count until it reaches zero, where the count stays. A level output, `idle_evt`, is high for as long as the count is zero. Other logic can wait on this level or sample it.

Software reaches the counter through a 32-bit register port. A write loads the low 16 bits and restarts the prescaler phase. A read returns the live count in the low 16 bits and zeros above them. Counting pauses in three cases: the operating mode is not acknowledged as valid, a dedicated halt bit is set, or a debug freeze is enabled while the CPU is halted in debug. In each case the prescaler phase is held, so no partial microsecond is lost.

Top module: `usdly_timer`

## Requirements
- R1: After reset the count is 0, `rd_data` reads 0 and `idle_evt` is high.
- R2: A write (`wr_en` high at a clock edge) loads `wr_data[15:0]` into the count. `wr_data[31:16]` is ignored and `rd_data[31:16]` always reads 0.
- R3: With no pause, the count falls by one on the clock edge CLK_MHZ cycles after the write edge, and then once every CLK_MHZ cycles.
- R4: The count stops at 0 and never wraps below zero.
- R5: `idle_evt` is high exactly when the count is 0. It rises in the cycle after a write of 0 and falls in the cycle after a write of a nonzero value.
- R6: Counting pauses while `dbg_freeze_en` and `cpu_dbg_halted` are both high. Either one alone does not pause counting.
- R7: Counting pauses while `halt_bit` is high, whatever the debug inputs are.
- R8: Counting pauses while `mode_ok` is low. Writes still load the count.
- R9: The prescaler phase is held during any pause. After the pause ends, the next decrement comes after the rest of the interrupted microsecond.
- R10: When a write and a tick fall on the same edge, the written value is loaded with no decrement, and the prescaler phase restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data; bits 15:0 are the delay |
| rd_data | output | 32 | Register read data; live count in bits 15:0 |
| mode_ok | input | 1 | Operating mode is acknowledged as active or low-power |
| dbg_freeze_en | input | 1 | Debug freeze enable |
| cpu_dbg_halted | input | 1 | CPU is halted in debug mode |
| halt_bit | input | 1 | Software timer-halt control bit |
| idle_evt | output | 1 | High while the count is zero |

## Verification
A write edge shows up at the ports in the next cycle: `rd_data` holds the loaded value and `idle_evt` follows at the same time. The first decrement lands exactly CLK_MHZ edges after the write edge. The bench drives inputs and samples outputs on falling edges. After each write it counts falling edges, checks the count one cycle before a decrement is due and again on the cycle the decrement lands, so an error of one cycle in either direction is caught. Pauses are started and ended on falling edges in the middle of a phase. The bench then works out where the resumed decrement must land from the number of edges that ran before the pause.

// File: rtl/usdly_pkg.sv
package usdly_pkg;
   // Conditions that can stop the microsecond count
   typedef struct packed {
      logic mode_ok;
      logic freeze_en;
      logic cpu_halted;
      logic halt_bit;
   } halt_req_t;

   function automatic int phase_width(input int div);
      return (div > 1) ? $clog2(div) : 1;
   endfunction
endpackage

// File: rtl/usdly_prescaler.sv
module usdly_prescaler #(
   parameter int DIV = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int PW = usdly_pkg::phase_width(DIV);
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] phase;

   assign tick = run && (phase == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (restart)
         phase <= '0;
      else if (tick)
         phase <= '0;
      else if (run)
         phase <= phase + 1'b1;
   end
endmodule

// File: rtl/usdly_halt_qual.sv
module usdly_halt_qual (
   input  usdly_pkg::halt_req_t req,
   output logic                 run
);
   logic dbg_stop;

   always_comb begin
      dbg_stop = req.freeze_en && req.cpu_halted;
      run      = req.mode_ok && !req.halt_bit && !dbg_stop;
   end
endmodule

// File: rtl/usdly_down_counter.sv
module usdly_down_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic [W-1:0] count,
   output logic         is_zero
);
   assign is_zero = (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (tick && !is_zero)
         count <= count - 1'b1;
   end
endmodule

// File: rtl/usdly_timer.sv
module usdly_timer #(
   parameter int CLK_MHZ = 48,
   parameter int COUNT_W = 16,
   parameter int BUS_W   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wr_data,
   output logic [BUS_W-1:0] rd_data,
   input  logic             mode_ok,
   input  logic             dbg_freeze_en,
   input  logic             cpu_dbg_halted,
   input  logic             halt_bit,
   output logic             idle_evt
);
   localparam int PAD_W = BUS_W - COUNT_W;

   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("usdly_timer: CLK_MHZ must be at least 1");
      end
      if (COUNT_W < 1 || COUNT_W >= BUS_W) begin : g_bad_width
         $error("usdly_timer: COUNT_W must be in 1..BUS_W-1");
      end
   endgenerate

   usdly_pkg::halt_req_t req;
   logic                 run;
   logic                 tick;
   logic [COUNT_W-1:0]   count;
   logic                 unused_upper;

   assign req.mode_ok    = mode_ok;
   assign req.freeze_en  = dbg_freeze_en;
   assign req.cpu_halted = cpu_dbg_halted;
   assign req.halt_bit   = halt_bit;

   assign unused_upper = ^wr_data[BUS_W-1:COUNT_W];

   usdly_halt_qual u_qual (
      .req (req),
      .run (run)
   );

   usdly_prescaler #(.DIV(CLK_MHZ)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (wr_en),
      .tick    (tick)
   );

   usdly_down_counter #(.W(COUNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_en),
      .load_val (wr_data[COUNT_W-1:0]),
      .tick     (tick),
      .count    (count),
      .is_zero  (idle_evt)
   );

   assign rd_data = {{PAD_W{1'b0}}, count};
endmodule

// File: rtl/usdly_timer_chk.sv
module usdly_timer_chk #(
   parameter int COUNT_W = 16,
   parameter int BUS_W   = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [BUS_W-1:0] wr_data,
   input logic [BUS_W-1:0] rd_data,
   input logic             mode_ok,
   input logic             dbg_freeze_en,
   input logic             cpu_dbg_halted,
   input logic             halt_bit,
   input logic             idle_evt
);
   logic [COUNT_W-1:0] cnt;
   assign cnt = rd_data[COUNT_W-1:0];

   assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[BUS_W-1:COUNT_W] == '0);

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cnt == $past(wr_data[COUNT_W-1:0]));

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - COUNT_W'(1)));

   assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && cnt == '0) |=> cnt == '0);

   assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      idle_evt == (cnt == '0));

   assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && dbg_freeze_en && cpu_dbg_halted) |=> $stable(cnt));

   assert_halt_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && halt_bit) |=> $stable(cnt));

   assert_mode_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !mode_ok) |=> $stable(cnt));
endmodule

bind usdly_timer usdly_timer_chk #(.COUNT_W(COUNT_W), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/usdly_timer_bench.sv
module usdly_timer_bench;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        mode_ok = 1'b1;
   logic        dbg_freeze_en = 1'b0;
   logic        cpu_dbg_halted = 1'b0;
   logic        halt_bit = 1'b0;
   logic        idle_evt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   usdly_timer #(.CLK_MHZ(DIV)) u_usdly_timer (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (wr_en),
      .wr_data        (wr_data),
      .rd_data        (rd_data),
      .mode_ok        (mode_ok),
      .dbg_freeze_en  (dbg_freeze_en),
      .cpu_dbg_halted (cpu_dbg_halted),
      .halt_bit       (halt_bit),
      .idle_evt       (idle_evt)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Drive a write for one edge; returns on the falling edge after it
   task automatic write_reg(input logic [31:0] v);
      wr_en   = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic t_reset();
      check("R1 count", rd_data, 32'h0);
      check("R1 idle", {31'b0, idle_evt}, 32'h1);
   endtask

   task automatic t_load();
      write_reg(32'hABCD_0005);
      check("R2 load low half, upper ignored", rd_data, 32'h5);
      check("R5 idle falls after nonzero write", {31'b0, idle_evt}, 32'h0);
      write_reg(32'hFFFF_0000);
      check("R5 idle rises after zero write", {31'b0, idle_evt}, 32'h1);
      check("R2 upper bits read zero", rd_data, 32'h0);
   endtask

   task automatic t_rate();
      write_reg(32'h3);
      cycles(DIV - 1);
      check("R3 no step before period", rd_data, 32'h3);
      cycles(1);
      check("R3 first step", rd_data, 32'h2);
      cycles(DIV - 1);
      check("R3 second step pending", rd_data, 32'h2);
      cycles(1);
      check("R3 second step", rd_data, 32'h1);
      check("R5 idle low while nonzero", {31'b0, idle_evt}, 32'h0);
      cycles(DIV);
      check("R3 reach zero", rd_data, 32'h0);
      check("R5 idle high at zero", {31'b0, idle_evt}, 32'h1);
      cycles(3 * DIV);
      check("R4 no wrap", rd_data, 32'h0);
   endtask

   task automatic t_freeze();
      write_reg(32'h5);
      dbg_freeze_en = 1'b1;
      cpu_dbg_halted = 1'b1;
      cycles(3 * DIV);
      check("R6 freeze holds count", rd_data, 32'h5);
      dbg_freeze_en = 1'b0;
      cycles(DIV - 1);
      check("R6 halted-cpu alone no step yet", rd_data, 32'h5);
      cycles(1);
      check("R6 halted-cpu alone counts", rd_data, 32'h4);
      cpu_dbg_halted = 1'b0;
      dbg_freeze_en = 1'b1;
      cycles(DIV);
      check("R6 freeze enable alone counts", rd_data, 32'h3);
      dbg_freeze_en = 1'b0;
   endtask

   task automatic t_halt_bit();
      write_reg(32'h4);
      halt_bit = 1'b1;
      dbg_freeze_en = 1'b0;
      cycles(4 * DIV);
      check("R7 halt bit holds count", rd_data, 32'h4);
      halt_bit = 1'b0;
      cycles(DIV);
      check("R7 resumes after halt bit", rd_data, 32'h3);
   endtask

   task automatic t_mode();
      mode_ok = 1'b0;
      write_reg(32'h6);
      check("R8 write loads while mode invalid", rd_data, 32'h6);
      cycles(3 * DIV);
      check("R8 no count while mode invalid", rd_data, 32'h6);
      mode_ok = 1'b1;
      cycles(DIV);
      check("R8 counts once mode valid", rd_data, 32'h5);
   endtask

   task automatic t_phase();
      write_reg(32'h5);
      cycles(2);
      halt_bit = 1'b1;
      cycles(10);
      halt_bit = 1'b0;
      cycles(DIV - 3);
      check("R9 phase held, no early step", rd_data, 32'h5);
      cycles(1);
      check("R9 step after remaining phase", rd_data, 32'h4);
   endtask

   task automatic t_write_wins();
      write_reg(32'h5);
      cycles(DIV - 1);
      write_reg(32'h9);
      check("R10 write beats tick", rd_data, 32'h9);
      cycles(DIV - 1);
      check("R10 phase restarted", rd_data, 32'h9);
      cycles(1);
      check("R10 step after fresh period", rd_data, 32'h8);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      t_reset();
      t_load();
      t_rate();
      t_freeze();
      t_halt_bit();
      t_mode();
      t_phase();
      t_write_wins();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule